// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block divides a selectable source clock by a time constant that software programs, and produces the square-wave bit clock for a serial controller. Software writes the 16-bit time constant as two bytes, then picks the source and sets the enable bit. The source is either an external clock pin or the processor (system) clock. The external pin is synchronized into the system clock domain, and each of its rising edges counts as one tick. With the processor source, every system clock cycle is a tick.

While enabled, a down counter starts at the time constant and loses one on each tick. On the tick that finds it at zero, it reloads and toggles the baud output. In that same cycle it raises a one-cycle zero-count pulse. Each half period of the baud output is therefore time constant + 1 ticks long. While disabled, the counter waits at the programmed constant and both outputs stay low. A new time constant written during operation is picked up only at the next reload.

Top module: `baud_divider`

## Requirements
- R1: After reset, `baud_out` and `zero_pulse` are 0, the generator is disabled, and the source select is 0 (external pin).
- R2: A write with `wr_addr` = 0 loads bits 7:0 of the time constant, `wr_addr` = 1 loads bits 15:8, and `wr_addr` = 2 loads the control register. A write to `wr_addr` = 3 has no effect on the outputs.
- R3: Control bit 0 is the enable (1 = run). Control bit 1 selects the source: 0 = external pin, 1 = processor clock.
- R4: With the external source, each rising edge of `ext_clk`, after a two-flop synchronizer, is one tick. Successive `zero_pulse` assertions are (TC+1) external periods apart.
- R5: With the processor source, successive `zero_pulse` assertions are exactly TC+1 system clock cycles apart. When TC = 0, `zero_pulse` is asserted on every cycle.
- R6: `baud_out` toggles in exactly the cycles in which `zero_pulse` is high, as long as the generator stays enabled.
- R7: While disabled, `baud_out` and `zero_pulse` stay 0 and the counter holds the time constant. After enable is set, the first `zero_pulse` arrives TC+1 ticks later.
- R8: A time-constant write while running leaves the count in progress unchanged. The new value governs the intervals after the next reload.
- R9: `zero_pulse` is high only in the cycle after a tick that found the counter at zero. Without a tick, the counter does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (processor) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External clock pin, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| baud_out | output | 1 | Square-wave baud clock |
| zero_pulse | output | 1 | One-cycle pulse on each counter reload |

## Verification
The bench targets the following cases:
- A time constant of zero. A counter that reloaded one cycle late would pulse every other cycle instead of every cycle.
- A constant with a nonzero high byte. Swapping or dropping a byte lane would give the wrong interval.
- A new constant written in the middle of a count. A design that loaded it at once would shorten the interval already in progress.
- Disable followed by re-enable. A counter not held at the constant would give a short first interval, and an output not forced low would leave `baud_out` stuck high.
- The external source. A missed or doubled edge detect would scale every interval.
- A write to the unused address. Decoding it as another register would change the intervals.

// File: rtl/baud_divider_pkg.sv
// Package: baud_divider_pkg
// Shared register addresses and control bit positions for the baud divider.
// Assumes a 2-bit register address space with byte-wide writes.
package baud_divider_pkg;

    // Register select codes seen on the write port
    typedef enum logic [1:0] {
        SEL_TC_LO = 2'd0,
        SEL_TC_HI = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Control register bit positions
    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_SRC_BIT = 1;

    // Decoded control state
    typedef struct packed {
        logic src_proc;   // 1 = processor clock, 0 = external pin
        logic run;        // 1 = generator running
    } ctrl_t;

endpackage

// File: rtl/baud_divider_regs.sv
// Module: baud_divider_regs
// Holds the programmable time constant, split into byte lanes, plus the
// control bits. Each byte lane is written on its own address.
// Assumes: writes land on the rising edge where wr_en is high. Reset clears
// everything, which leaves the generator disabled on the external source.
module baud_divider_regs
    import baud_divider_pkg::*;
#(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned N_BYTES = 2,
    localparam int unsigned TC_W   = BYTE_W * N_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [TC_W-1:0]   tc,
    output ctrl_t             ctrl
);

    // One register per time-constant byte, each on its own address
    for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        // Capture this byte when its address is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (wr_en && (wr_addr == 2'(g))) begin
                lane_q <= wr_data;
            end
        end

        assign tc[g*BYTE_W +: BYTE_W] = lane_q;
    end

    // Control register: enable and source select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en && (wr_addr == SEL_CTRL)) begin
            ctrl.run      <= wr_data[CTRL_RUN_BIT];
            ctrl.src_proc <= wr_data[CTRL_SRC_BIT];
        end
    end

endmodule

// File: rtl/baud_divider_tick.sv
// Module: baud_divider_tick
// Produces a one-cycle tick from the selected source. With the processor
// clock the tick is high on every cycle. With the external pin it is high
// for one cycle after each synchronized rising edge.
// Assumes: ext_clk is asynchronous and its high and low phases each last
// at least two system clock cycles.
module baud_divider_tick #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic src_proc,
    output logic tick
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   ext_rise;

    // First synchronizer stage samples the asynchronous pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= ext_clk;
    end

    // Remaining synchronizer stages
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    // Rising-edge detect and source selection
    always_comb begin
        ext_rise = sync_q[SYNC_STAGES-1] & ~last_q;
        tick     = src_proc ? 1'b1 : ext_rise;
    end

endmodule

// File: rtl/baud_divider_count.sv
// Module: baud_divider_count
// Down counter with reload. While running, each tick lowers the count by
// one. A tick at zero reloads the time constant, toggles the baud output
// and raises the zero pulse for one cycle. While stopped, the count follows
// the time constant and both outputs are low.
// Assumes: tc stays stable for the whole count, except at a reload.
module baud_divider_count #(
    parameter int unsigned TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic [TC_W-1:0] tc,
    output logic [TC_W-1:0] count,
    output logic            baud_out,
    output logic            zero_pulse
);

    logic at_zero;

    // Detect the terminal count
    always_comb begin
        at_zero = (count == '0);
    end

    // Count, reload and toggle state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            baud_out   <= 1'b0;
            zero_pulse <= 1'b0;
        end else if (!run) begin
            count      <= tc;
            baud_out   <= 1'b0;
            zero_pulse <= 1'b0;
        end else begin
            zero_pulse <= 1'b0;
            if (tick) begin
                if (at_zero) begin
                    count      <= tc;
                    baud_out   <= ~baud_out;
                    zero_pulse <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/baud_divider.sv
// Module: baud_divider
// Top level of the programmable baud rate generator. It joins the register
// file, the tick source and the down counter.
// Assumes: a single system clock; ext_clk is asynchronous to it.
module baud_divider
    import baud_divider_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned TC_W       = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              baud_out,
    output logic              zero_pulse
);

    logic [TC_W-1:0] tc_val;
    logic [TC_W-1:0] count_q;
    ctrl_t           ctrl_q;
    logic            tick;
    logic            run_en;

    assign run_en = ctrl_q.run;

    baud_divider_regs #(
        .BYTE_W  (BYTE_W),
        .N_BYTES (2)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tc      (tc_val),
        .ctrl    (ctrl_q)
    );

    baud_divider_tick #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_clk  (ext_clk),
        .src_proc (ctrl_q.src_proc),
        .tick     (tick)
    );

    baud_divider_count #(
        .TC_W (TC_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_en),
        .tick       (tick),
        .tc         (tc_val),
        .count      (count_q),
        .baud_out   (baud_out),
        .zero_pulse (zero_pulse)
    );

endmodule

// File: rtl/baud_divider_checker.sv
// Module: baud_divider_checker
// Temporal properties of the baud divider, attached by bind.
module baud_divider_checker #(
    parameter int unsigned TC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic            tick,
    input logic [TC_W-1:0] count_q,
    input logic            baud_out,
    input logic            zero_pulse
);

    AST_TOGGLE_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |-> (baud_out != $past(baud_out))); // R6

    AST_EDGE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((baud_out != $past(baud_out)) && $past(run_en)) |-> zero_pulse); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!baud_out && !zero_pulse)); // R7

    AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |-> ($past(tick) && $past(run_en))); // R9

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !tick) |=> $stable(count_q)); // R9

endmodule

bind baud_divider baud_divider_checker #(.TC_W(TC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .tick       (tick),
    .count_q    (count_q),
    .baud_out   (baud_out),
    .zero_pulse (zero_pulse)
);

// File: tb/baud_divider_test.sv
module baud_divider_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       baud_out;
    logic       zero_pulse;

    int checks = 0;
    int fails  = 0;
    localparam int EXT_HALF = 3;

    baud_divider uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_clk    (ext_clk),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .baud_out   (baud_out),
        .zero_pulse (zero_pulse)
    );

    always #4 clk = ~clk;

    // Free-running external clock, period 2*EXT_HALF system cycles
    initial begin
        forever begin
            repeat (EXT_HALF) @(negedge clk);
            ext_clk = ~ext_clk;
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    function automatic int exp_interval(input int tc, input bit src_proc);
        return (src_proc ? 1 : 2 * EXT_HALF) * (tc + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!zero_pulse && n < 50000);
    endtask

    // Program, enable, then check two intervals and the toggle
    task automatic run_case(input int tc, input bit src, input string req);
        int n;
        logic b0;
        wr(2'd2, 8'h00);
        wr(2'd0, tc[7:0]);
        wr(2'd1, tc[15:8]);
        wr(2'd2, {6'd0, src, 1'b1});
        wait_pulse(n);
        b0 = baud_out;
        wait_pulse(n);
        check(n == exp_interval(tc, src), req, n, exp_interval(tc, src));
        check(baud_out != b0, "R6 toggle", baud_out, !b0);
        wait_pulse(n);
        check(n == exp_interval(tc, src), req, n, exp_interval(tc, src));
        check(baud_out == b0, "R6 toggle back", baud_out, b0);
    endtask

    initial begin
        int n;
        bit quiet;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(baud_out == 1'b0, "R1 baud_out", baud_out, 0);
        check(zero_pulse == 1'b0, "R1 zero_pulse", zero_pulse, 0);

        // R7: programmed but not enabled stays quiet
        wr(2'd0, 8'd3);
        quiet = 1'b1;
        repeat (100) begin @(negedge clk); if (baud_out || zero_pulse) quiet = 1'b0; end
        check(quiet, "R7 idle while disabled", quiet, 1);

        // R5: processor source, including TC = 0
        run_case(0, 1'b1, "R5 tc0");
        run_case(3, 1'b1, "R5 tc3");
        // R2: high byte lane
        run_case(16'h0105, 1'b1, "R2 high byte");
        // R3/R4: external source
        run_case(2, 1'b0, "R4 ext tc2");
        run_case(0, 1'b0, "R3 ext tc0");

        // R8: mid-count change, plus R2 write to unused address
        run_case(20, 1'b1, "R8 base");
        wait_pulse(n);
        wr(2'd0, 8'd5);
        wr(2'd1, 8'd0);
        wr(2'd3, 8'hFF);
        wait_pulse(n);
        check(n == 21 - 6, "R8 current count kept (partial)", n, 15);
        wait_pulse(n);
        check(n == 6, "R8 new constant after reload", n, 6);
        wait_pulse(n);
        check(n == 6, "R2 unused address ignored", n, 6);

        // R7: disable mid-run forces quiet outputs
        wr(2'd2, 8'h00);
        quiet = 1'b1;
        repeat (50) begin @(negedge clk); if (baud_out || zero_pulse) quiet = 1'b0; end
        check(quiet, "R7 quiet after disable", quiet, 1);

        // R7: first pulse comes TC+1 ticks after enable
        wr(2'd2, 8'h03);
        wait_pulse(n);
        check(n == 6, "R7 first interval after enable", n, 6);
        check(baud_out == 1'b1, "R7 first toggle from low", baud_out, 1);

        // Random mix of constants and sources
        for (int i = 0; i < 8; i++) begin
            int tc;
            bit src;
            tc  = int'($urandom_range(0, 30));
            src = 1'($urandom_range(0, 1));
            run_case(tc, src, src ? "R5 random" : "R4 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule